// File: doc/BRIEF.md
# Banked Multifunction Pin Configuration Register File

This block holds the configuration and data of 32 multifunction pins, split into two groups of sixteen: pin indices 0 to 15 form group A and indices 16 to 31 form group B. Each pin works as an analog converter input, a digital input or a digital output. A byte-wide register port reaches sixteen 8-bit registers arranged in four banks of four. The banks are sampled input levels, input enables, output enables and output levels. The block samples the external pin levels through a two-flop synchronizer. It drives each pad's output level and output enable, and it gives the converter path one flag per pin that says the pin is currently claimed for digital use.

Each pin is in one of three modes, and the mode is decoded from its two enable bits. The modes are PIN_ANALOG (neither bit set), PIN_DIN (input enable only) and PIN_DOUT (output enable set, whatever the input enable holds). The mode changes only when software writes an enable byte:

- Setting the output enable takes a pin from any mode to PIN_DOUT.
- Clearing the output enable while the input enable is set gives PIN_DIN.
- Clearing both bits gives PIN_ANALOG.

Reset puts every pin in PIN_ANALOG. The sampled-level bank cannot be written and always shows the synchronized pad levels.

Inside each bank the byte lanes run in reverse order, so the lowest-numbered pins sit at the highest address of the bank. Software addresses a pin as (bank base + 3 − n/8), bit (n mod 8).

Top module: `gpiomux_regfile`

## Requirements
- R1: After reset, every enable and output-level register reads 0, and pin_oe, pin_out and is_gpio are all 0.
- R2: Address bits [3:2] select the bank: 0 = sampled input levels, 1 = input enables, 2 = output enables, 3 = output levels. The read data is combinational from addr.
- R3: Address bits [1:0] select a byte lane in reverse order. Pin n is at bank offset 3 − n/8, bit n mod 8. Pins 0–15 are group A and pins 16–31 are group B.
- R4: A write with wr_en high updates the addressed enable or output-level byte at the next rising edge. That byte then reads back exactly as written, and no other byte changes.
- R5: A pin whose output-enable bit is 1 is in PIN_DOUT whatever its input-enable bit holds. Its pin_oe is 1 and its pin_out equals its output-level bit.
- R6: A pin with input enable 1 and output enable 0 is in PIN_DIN, with pin_oe 0 and pin_out 0.
- R7: A pin with both enable bits 0 is in PIN_ANALOG, with pin_oe 0, pin_out 0 and is_gpio 0.
- R8: is_gpio bit n is the OR of pin n's input-enable and output-enable bits.
- R9: A change on pin_in shows in the sampled-level bank after the second rising edge and not after the first.
- R10: In the sampled-level bank, bits of pins that are not in PIN_DIN read 0.
- R11: Writes to the sampled-level bank (addresses 0–3) change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register address: bank in [3:2], reversed lane in [1:0] |
| wr_en | input | 1 | Write strobe for the addressed byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed byte (combinational) |
| pin_in | input | 32 | Asynchronous pad input levels |
| pin_out | output | 32 | Pad output levels, 0 unless the pin is an output |
| pin_oe | output | 32 | Pad output enables |
| is_gpio | output | 32 | Per-pin digital-use flag for the converter path |

## Verification
The hardest condition to reach is a pin with both enable bits set. Software never needs that state, yet the priority rule has to resolve it. The bench reaches it by sweeping every pin through all four combinations of its two enable bits, rewriting all eight enable bytes each time. That sweep also exercises the reversed lane mapping for every pin. The window where only the first synchronizer stage has caught a new pad level is the other hard case. The bench reaches it by changing pin_in at a falling edge and reading the sampled bank between the two following rising edges.

// File: rtl/gpiomux_pkg.sv
package gpiomux_pkg;

    typedef enum logic [1:0] {
        BANK_IN_VAL  = 2'd0,
        BANK_IN_EN   = 2'd1,
        BANK_OUT_EN  = 2'd2,
        BANK_OUT_VAL = 2'd3
    } bank_e;

    typedef enum logic [1:0] {
        PIN_ANALOG = 2'd0,
        PIN_DIN    = 2'd1,
        PIN_DOUT   = 2'd2
    } pin_mode_e;

    // Output enable wins over input enable.
    function automatic pin_mode_e decode_mode(input logic ie, input logic oe);
        if (oe)
            return PIN_DOUT;
        else if (ie)
            return PIN_DIN;
        else
            return PIN_ANALOG;
    endfunction

endpackage

// File: rtl/gpiomux_sync.sv
module gpiomux_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;

    // Edges since reset, saturating at 2, so that $past never reaches into reset.
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            age_q <= 2'd0;
        else if (age_q != 2'd2)
            age_q <= age_q + 2'd1;
    end

    p_two_stage_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (q == $past(d, 2)));

endmodule

// File: rtl/gpiomux_bank.sv
module gpiomux_bank #(
    parameter int NPINS  = 32,
    parameter int BYTE_W = 8,
    localparam int LANES  = NPINS / BYTE_W,
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LANE_W-1:0] lane,
    input  logic [BYTE_W-1:0] wdata,
    output logic [NPINS-1:0]  q
);

    for (genvar b = 0; b < LANES; b++) begin : g_byte
        // Reverse ordering: byte 0 (lowest pins) sits at the highest lane.
        localparam logic [LANE_W-1:0] MY_LANE = LANE_W'(LANES - 1 - b);

        logic [BYTE_W-1:0] byte_q;
        logic              hit;

        assign hit = wr_en && (lane == MY_LANE);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                byte_q <= '0;
            else if (hit)
                byte_q <= wdata;
        end

        assign q[b*BYTE_W +: BYTE_W] = byte_q;

        p_lane_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && lane == MY_LANE) |=> (q[b*BYTE_W +: BYTE_W] == $past(wdata)));

        p_lane_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && lane == MY_LANE) |=> $stable(q[b*BYTE_W +: BYTE_W]));
    end

endmodule

// File: rtl/gpiomux_pin_mode.sv
module gpiomux_pin_mode
    import gpiomux_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0] in_en,
    input  logic [NPINS-1:0] out_en,
    input  logic [NPINS-1:0] out_val,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] in_mask,
    output logic [NPINS-1:0] digital
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pin_mode_e mode;
        logic      oe_l;
        logic      out_l;
        logic      in_l;

        assign mode = decode_mode(in_en[i], out_en[i]);

        always_comb begin
            oe_l  = 1'b0;
            out_l = 1'b0;
            in_l  = 1'b0;
            unique case (mode)
                PIN_DOUT: begin
                    oe_l  = 1'b1;
                    out_l = out_val[i];
                end
                PIN_DIN: begin
                    in_l = 1'b1;
                end
                PIN_ANALOG: begin
                end
                default: begin
                end
            endcase
        end

        assign pad_oe[i]  = oe_l;
        assign pad_out[i] = out_l;
        assign in_mask[i] = in_l;
        assign digital[i] = (mode != PIN_ANALOG);
    end

endmodule

// File: rtl/gpiomux_regfile.sv
module gpiomux_regfile
    import gpiomux_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int BYTE_W = 8,
    localparam int LANES  = NPINS / BYTE_W,
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int ADDR_W = LANE_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  is_gpio
);

    bank_e             bank_sel;
    logic [LANE_W-1:0] lane_sel;
    logic [LANE_W-1:0] byte_idx;
    logic [NPINS-1:0]  bank_q [4];
    logic [NPINS-1:0]  sync_q;
    logic [NPINS-1:0]  in_mask;

    assign bank_sel = bank_e'(addr[ADDR_W-1 -: 2]);
    assign lane_sel = addr[LANE_W-1:0];
    assign byte_idx = LANE_W'(LANES - 1) - lane_sel;

    // Writable banks 1..3; bank 0 has no storage of its own.
    for (genvar g = 1; g < 4; g++) begin : g_bank
        gpiomux_bank #(
            .NPINS  (NPINS),
            .BYTE_W (BYTE_W)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_en && (addr[ADDR_W-1 -: 2] == 2'(g))),
            .lane  (lane_sel),
            .wdata (wdata),
            .q     (bank_q[g])
        );
    end

    gpiomux_sync #(
        .WIDTH (NPINS)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (sync_q)
    );

    gpiomux_pin_mode #(
        .NPINS (NPINS)
    ) u_mode (
        .in_en   (bank_q[1]),
        .out_en  (bank_q[2]),
        .out_val (bank_q[3]),
        .pad_oe  (pin_oe),
        .pad_out (pin_out),
        .in_mask (in_mask),
        .digital (is_gpio)
    );

    assign bank_q[0] = sync_q & in_mask;

    always_comb begin
        rdata = '0;
        unique case (bank_sel)
            BANK_IN_VAL:  rdata = bank_q[0][byte_idx*BYTE_W +: BYTE_W];
            BANK_IN_EN:   rdata = bank_q[1][byte_idx*BYTE_W +: BYTE_W];
            BANK_OUT_EN:  rdata = bank_q[2][byte_idx*BYTE_W +: BYTE_W];
            BANK_OUT_VAL: rdata = bank_q[3][byte_idx*BYTE_W +: BYTE_W];
            default:      rdata = '0;
        endcase
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (is_gpio == '0 && pin_oe == '0 && pin_out == '0));

    p_drive_only_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ~pin_oe) == '0));

    p_oe_is_gpio_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe & ~is_gpio) == '0));

    p_inval_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bank_sel == BANK_IN_VAL) |=>
            ($stable(bank_q[1]) && $stable(bank_q[2]) && $stable(bank_q[3])));

    p_inval_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_sel == BANK_IN_VAL) |->
            ((rdata & pin_oe[byte_idx*BYTE_W +: BYTE_W]) == '0));

endmodule

// File: tb/gpiomux_regfile_test.sv
`timescale 1ns/1ps
module gpiomux_regfile_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic [31:0] is_gpio;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Bench model of the writable banks
    logic [31:0] ie_m = '0;
    logic [31:0] oe_m = '0;
    logic [31:0] ov_m = '0;

    always #2.5 clk = ~clk;

    gpiomux_regfile uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wdata   (wdata),
        .rdata   (rdata),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .is_gpio (is_gpio)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected read value: bank in a[3:2], byte (3 - a[1:0]).
    function automatic logic [7:0] exp_rd(input logic [3:0] a);
        logic [31:0] v;
        int b;
        b = 3 - int'(a[1:0]);
        case (a[3:2])
            2'd0:    v = pin_in & ie_m & ~oe_m;
            2'd1:    v = ie_m;
            2'd2:    v = oe_m;
            default: v = ov_m;
        endcase
        return v[b*8 +: 8];
    endfunction

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        int b;
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        b = 3 - int'(a[1:0]);
        case (a[3:2])
            2'd1:    ie_m[b*8 +: 8] = d;
            2'd2:    oe_m[b*8 +: 8] = d;
            2'd3:    ov_m[b*8 +: 8] = d;
            default: ;
        endcase
    endtask

    task automatic rd_check(input string tag, input logic [3:0] a);
        addr = a;
        #1;
        check(tag, {24'h0, rdata}, {24'h0, exp_rd(a)});
    endtask

    task automatic out_check(input string tag);
        check({tag, " pin_oe"}, pin_oe, oe_m);
        check({tag, " pin_out"}, pin_out, ov_m & oe_m);
        check({tag, " is_gpio"}, is_gpio, ie_m | oe_m);
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        pin_in = 32'hDEAD_BEEF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R7: reset state
        for (int a = 0; a < 16; a++) rd_check("R1 reset readback", 4'(a));
        out_check("R1 R7 reset outputs");

        // R2, R3, R4: every writable byte gets a distinct value, all bytes read back
        for (int a = 4; a < 16; a++) wr(4'(a), 8'(a * 29 + 7));
        for (int a = 0; a < 16; a++) rd_check("R2 R3 R4 bank/lane readback", 4'(a));
        out_check("R5 R8 after pattern fill");

        // R11: writes to the sampled bank change nothing
        for (int a = 0; a < 4; a++) wr(4'(a), 8'hFF ^ 8'(a));
        for (int a = 0; a < 16; a++) rd_check("R11 sampled bank write ignored", 4'(a));
        out_check("R11 outputs unchanged");

        // R9: synchronizer latency, all pins as inputs
        for (int a = 4; a < 8; a++) wr(4'(a), 8'hFF);
        for (int a = 8; a < 12; a++) wr(4'(a), 8'h00);
        pin_in = '0;
        repeat (3) @(negedge clk);
        pin_in = 32'h1234_5678;
        addr = 4'd3;
        @(negedge clk); #1;
        check("R9 one edge: old value", {24'h0, rdata}, 32'h0);
        @(negedge clk); #1;
        check("R9 two edges: pins A0-A7 at offset 3", {24'h0, rdata}, 32'h78);
        addr = 4'd0; #1;
        check("R3 pins B8-B15 at offset 0", {24'h0, rdata}, 32'h12);
        addr = 4'd2; #1;
        check("R3 pins A8-A15 at offset 2", {24'h0, rdata}, 32'h56);

        // R5-R8, R10, R3: every pin through all four enable combinations
        for (int a = 12; a < 16; a++) wr(4'(a), 8'hA5 ^ 8'(a * 3));
        for (int p = 0; p < 32; p++) begin
            for (int c = 0; c < 4; c++) begin
                logic [31:0] ie_v;
                logic [31:0] oe_v;
                ie_v = c[0] ? (32'h1 << p) : 32'h0;
                oe_v = c[1] ? (32'h1 << p) : 32'h0;
                for (int l = 0; l < 4; l++) begin
                    wr(4'(4 + l), ie_v[(3 - l)*8 +: 8]);
                    wr(4'(8 + l), oe_v[(3 - l)*8 +: 8]);
                end
                pin_in = c[0] ? 32'h9C3A_61E5 : 32'h63C5_9E1A;
                repeat (2) @(negedge clk);
                out_check($sformatf("R5 R6 R7 R8 pin %0d combo %0d", p, c));
                rd_check($sformatf("R10 R3 sampled pin %0d combo %0d", p, c), 4'(3 - p / 8));
            end
        end

        finished = 1;
        summary();
        $finish;
    end

endmodule